// File: doc/BRIEF.md
# Register-Controlled MDIO Management Master

This block is a management-bus master that software drives through five small registers. Software puts the PHY address and register number into an address register and, for a write, puts a 16-bit value into a write-data register. It then sets either the read-request bit or the write-request bit in a control register. The block shifts out one Clause 22 management frame on MDC and MDIO. MDIO is presented as a separate output, an output enable and an input, so that the tristate pad sits outside the block.

While a frame is on the wire, a status bit reads 1, and software polls it until it drops. For a read, the block releases the line for the turnaround and the data phase. It samples the 16 bits returned by the PHY, MSB first, and keeps them in a read-data register. MDC is derived from the system clock by an even division factor. It runs only while a frame is active and rests low otherwise. A frame takes exactly 64 MDC periods, far below the 10 ms after which software gives up on an access.

Top module: `mdio_regs_master`

## Requirements
- R1: After reset the status busy bit (status register, selector 3, bit 0) is 0, the read-data register (selector 4) and the control register (selector 2) read 0, and mdc and mdio_oe are low.
- R2: The address register (selector 0) keeps the PHY address in bits 12:8 and the register number in bits 4:0; all other bits read back as 0.
- R3: Writing the control register with bit 3 set (read request) starts a frame of 32 ones, start bits 01, opcode 10, the PHY address and the register number, each field MSB first.
- R4: Writing the control register with bit 2 set (write request) starts a frame with opcode 01, turnaround 10 and bits 15:0 of the write-data register (selector 1) MSB first, with mdio_oe high for the whole frame.
- R5: A control write that sets both bits performs a write; during that frame the control register reads 0x4 (read request cleared), and after the frame it reads 0.
- R6: The busy bit reads 1 from the clock edge that accepts a request until the frame ends, and the frame ends no more than 64 x CLK_DIV system clocks after the request.
- R7: In a read frame mdio_oe is low from the first turnaround bit to the end of the frame; the 16 data bits sampled on MDC rising edges appear MSB first in bits 15:0 of the read-data register, and bits 31:16 read 0.
- R8: MDC has a period of CLK_DIV system clocks, with CLK_DIV/2 clocks in each level, and mdio_o changes only on MDC falling edges within a frame.
- R9: A control write made while a frame is in progress is ignored: it starts no further frame.
- R10: When no frame is in progress, mdc stays low and mdio_oe stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 3 | Register selector: 0 address, 1 write data, 2 control, 3 status, 4 read data |
| reg_wen | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable (1 = block drives the line) |
| mdio_i | input | 1 | Management data in (resolved line) |

## Verification
A bit counter or shift register that goes wrong shows up as a malformed frame. The bench compares the frame in full at the 64th MDC rising edge, so an error is caught within one frame. A busy flag that drops early or hangs shows on the status bit within the poll window of one frame. A stuck flag also shows as a missing or extra burst of MDC edges, which the bench sees as a bit count other than 64. A wrong divider count changes the spacing of the first two MDC rising edges, which is visible two MDC periods into a frame. A read-capture fault appears in the read-data register on the first read after the frame ends.

// File: rtl/mdio_mgmt_pkg.sv
// Package: shared constants, selector codes and request type for the
// register-controlled MDIO master. Assumes Clause 22 frames only.
package mdio_mgmt_pkg;

    localparam int PHY_W    = 5;
    localparam int REGN_W   = 5;
    localparam int DATA_W   = 16;
    localparam int BUS_W    = 32;
    localparam int PHY_LSB  = 8;

    localparam int CTRL_RD   = 3;
    localparam int CTRL_WR   = 2;
    localparam int STAT_BUSY = 0;

    localparam int PRE_LEN    = 32;
    localparam int HDR_LEN    = PRE_LEN + 2 + 2 + PHY_W + REGN_W;
    localparam int DATA_FIRST = HDR_LEN + 2;
    localparam int FRAME_LEN  = DATA_FIRST + DATA_W;

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_RD    = 2'b10;
    localparam logic [1:0] OP_WR    = 2'b01;
    localparam logic [1:0] TA_WR    = 2'b10;

    typedef enum logic [2:0] {
        SEL_ADDR  = 3'd0,
        SEL_WDATA = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_STAT  = 3'd3,
        SEL_RDATA = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic              is_rd;
        logic [PHY_W-1:0]  phy;
        logic [REGN_W-1:0] regn;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

endpackage

// File: rtl/mdio_mgmt_regs.sv
// Register file: holds the address, write data, control request bits and
// captured read data. It issues a one-cycle start when a control write
// carries a request while the engine is idle. Assumes a single-cycle write
// strobe and a combinational read port.
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_sel,
    input  logic             reg_wen,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic             busy,
    input  logic             done,
    input  logic             rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic             start,
    output mdio_req_t        req
);

    logic [PHY_W-1:0]  phy_q;
    logic [REGN_W-1:0] regn_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ctrl_rd_q;
    logic              ctrl_wr_q;
    logic              wr_ctrl;
    logic              want_wr;
    logic              want_rd;
    logic              unused_hi;

    assign unused_hi = ^reg_wdata[BUS_W-1:DATA_W];

    // Decode a control write; a write request masks a read request.
    always_comb begin
        wr_ctrl = reg_wen && (reg_sel == SEL_CTRL);
        want_wr = reg_wdata[CTRL_WR];
        want_rd = reg_wdata[CTRL_RD] && !reg_wdata[CTRL_WR];
        start   = wr_ctrl && !busy && (want_wr || want_rd);
    end

    // Present the request fields to the frame engine.
    always_comb begin
        req.is_rd = want_rd;
        req.phy   = phy_q;
        req.regn  = regn_q;
        req.wdata = wdata_q;
    end

    // Address and write-data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q   <= '0;
            regn_q  <= '0;
            wdata_q <= '0;
        end else if (reg_wen) begin
            if (reg_sel == SEL_ADDR) begin
                phy_q  <= reg_wdata[PHY_LSB +: PHY_W];
                regn_q <= reg_wdata[REGN_W-1:0];
            end
            if (reg_sel == SEL_WDATA) begin
                wdata_q <= reg_wdata[DATA_W-1:0];
            end
        end
    end

    // Request bits: set by an accepted control write, cleared at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_rd_q <= 1'b0;
            ctrl_wr_q <= 1'b0;
        end else if (start) begin
            ctrl_rd_q <= want_rd;
            ctrl_wr_q <= want_wr;
        end else if (done) begin
            ctrl_rd_q <= 1'b0;
            ctrl_wr_q <= 1'b0;
        end
    end

    // Read-data register, loaded when a read frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_valid) begin
            rdata_q <= rd_data;
        end
    end

    // Read multiplexer over the five registers.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_ADDR: begin
                reg_rdata[PHY_LSB +: PHY_W] = phy_q;
                reg_rdata[REGN_W-1:0]       = regn_q;
            end
            SEL_WDATA: reg_rdata[DATA_W-1:0] = wdata_q;
            SEL_CTRL: begin
                reg_rdata[CTRL_RD] = ctrl_rd_q;
                reg_rdata[CTRL_WR] = ctrl_wr_q;
            end
            SEL_STAT:  reg_rdata[STAT_BUSY]  = busy;
            SEL_RDATA: reg_rdata[DATA_W-1:0] = rdata_q;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_clkdiv.sv
// MDC generator: divides the system clock by CLK_DIV (even, at least 2)
// while enabled and rests low when disabled. rise and fall are high in the
// cycle whose closing edge takes MDC high or low.
module mdio_mgmt_clkdiv #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise,
    output logic fall
);

    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic wrap;
    logic mdc_q;

    generate
        if (HALF == 1) begin : g_fast
            assign wrap = 1'b1;
        end else begin : g_cnt
            logic [CW-1:0] cnt_q;
            // Half-period counter, held at zero while disabled.
            always_ff @(posedge clk) begin
                if (!rst_n || !en) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(HALF - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
            assign wrap = (cnt_q == CW'(HALF - 1));
        end
    endgenerate

    // MDC level: toggles at each half-period wrap, low when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            mdc_q <= 1'b0;
        end else if (wrap) begin
            mdc_q <= !mdc_q;
        end
    end

    assign mdc  = mdc_q;
    assign rise = en && wrap && !mdc_q;
    assign fall = en && wrap && mdc_q;

endmodule

// File: rtl/mdio_mgmt_frame.sv
// Frame engine: loads a 64-bit Clause 22 frame at start, shifts it out one
// bit per MDC period on falling edges, releases the line for the read
// turnaround and data, and shifts in 16 read bits on rising edges.
// Assumes rise and fall never occur in the same cycle.
module mdio_mgmt_frame
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              rd_mode,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] HDR_IDX  = IDX_W'(HDR_LEN);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);

    logic                 busy_q;
    logic                 rd_q;
    logic                 oe_q;
    logic [IDX_W-1:0]     idx_q;
    logic [IDX_W-1:0]     idx_nx;
    logic [FRAME_LEN-1:0] sh_q;
    logic [FRAME_LEN-1:0] load_frame;
    logic [DATA_W-1:0]    cap_q;

    // Assemble the frame image for the request being accepted.
    always_comb begin
        load_frame = {{PRE_LEN{1'b1}}, SOF_BITS,
                      req.is_rd ? OP_RD : OP_WR,
                      req.phy, req.regn,
                      req.is_rd ? 2'b11 : TA_WR,
                      req.is_rd ? {DATA_W{1'b1}} : req.wdata};
        idx_nx = idx_q + IDX_W'(1);
    end

    // Frame sequencing: load, shift on MDC falls, capture on MDC rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            oe_q   <= 1'b0;
            idx_q  <= '0;
            sh_q   <= '1;
            cap_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                rd_q   <= req.is_rd;
                oe_q   <= 1'b1;
                idx_q  <= '0;
                sh_q   <= load_frame;
                cap_q  <= '0;
            end
        end else begin
            if (rise && rd_q && (idx_q >= DAT_IDX)) begin
                cap_q <= {cap_q[DATA_W-2:0], mdio_i};
            end
            if (fall) begin
                if (idx_q == LAST_IDX) begin
                    busy_q <= 1'b0;
                    oe_q   <= 1'b0;
                    sh_q   <= '1;
                end else begin
                    idx_q <= idx_nx;
                    sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
                    oe_q  <= !rd_q || (idx_nx < HDR_IDX);
                end
            end
        end
    end

    assign busy     = busy_q;
    assign rd_mode  = rd_q;
    assign mdio_o   = sh_q[FRAME_LEN-1];
    assign mdio_oe  = oe_q;
    assign done     = busy_q && fall && (idx_q == LAST_IDX);
    assign rd_valid = done && rd_q;
    assign rd_data  = cap_q;

endmodule

// File: rtl/mdio_regs_master.sv
// Top: register-controlled Clause 22 MDIO master. Connects the register
// file, MDC divider and frame engine. Assumes CLK_DIV is even and >= 2;
// the pad tristate is built outside from mdio_o and mdio_oe.
module mdio_regs_master
    import mdio_mgmt_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_sel,
    input  logic        reg_wen,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic              eng_busy;
    logic              eng_rd;
    logic              eng_done;
    logic              eng_rd_valid;
    logic [DATA_W-1:0] eng_rd_data;
    logic              tick_rise;
    logic              tick_fall;
    logic              start;
    mdio_req_t         req;

    mdio_mgmt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (eng_busy),
        .done      (eng_done),
        .rd_valid  (eng_rd_valid),
        .rd_data   (eng_rd_data),
        .start     (start),
        .req       (req)
    );

    mdio_mgmt_clkdiv #(
        .CLK_DIV (CLK_DIV)
    ) u_clkdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (eng_busy),
        .mdc   (mdc),
        .rise  (tick_rise),
        .fall  (tick_fall)
    );

    mdio_mgmt_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .req      (req),
        .rise     (tick_rise),
        .fall     (tick_fall),
        .mdio_i   (mdio_i),
        .busy     (eng_busy),
        .rd_mode  (eng_rd),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (eng_done),
        .rd_valid (eng_rd_valid),
        .rd_data  (eng_rd_data)
    );

endmodule

// File: rtl/mdio_regs_master_chk.sv
// Checker: temporal properties of the MDIO master pins, bound to the top.
// Assumes the frame length of 64 MDC periods.
module mdio_regs_master_chk #(
    parameter int CLK_DIV = 8
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic rd_mode,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);

    localparam int HALF     = CLK_DIV / 2;
    localparam int MAX_BUSY = 64 * CLK_DIV;

    logic [31:0] busy_cnt;
    logic [31:0] hcnt;
    logic        mdc_d;

    // Length of the current busy stretch, and cycles since the last MDC edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            hcnt     <= '0;
            mdc_d    <= 1'b0;
        end else begin
            busy_cnt <= busy ? busy_cnt + 32'd1 : 32'd0;
            hcnt     <= (!busy || (mdc != mdc_d)) ? 32'd0 : hcnt + 32'd1;
            mdc_d    <= mdc;
        end
    end

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < 32'(MAX_BUSY)));

    assert_change_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

    assert_mdc_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mdc_d && !mdc) |-> (hcnt == 32'(HALF - 1)));

    assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_mode) |-> mdio_oe);

endmodule

bind mdio_regs_master mdio_regs_master_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (eng_busy),
    .rd_mode (eng_rd),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_regs_master_tb.sv
// Scoreboard bench: a driver task queues the expected line image of each
// frame, a PHY responder records and answers the frame, and a monitor
// compares the recorded frame against the queue head.
module mdio_regs_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 8;
    localparam int FRAME_CYC  = 64 * CLK_DIV;

    typedef struct {
        logic [63:0] line;
        logic [63:0] oe;
        bit          rd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_drv = 1'b1;
    logic        mdio_line;

    int          checks = 0;
    int          errors = 0;
    int          ph_cnt = 64;
    logic [63:0] cap_line = '0;
    logic [63:0] cap_oe = '0;
    logic [15:0] rsp_data = '0;
    time         t_first, t_second;
    exp_t        sb_q[$];
    event        frame_ev;

    assign mdio_line = mdio_oe ? mdio_o : phy_drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_regs_master #(.CLK_DIV(CLK_DIV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_line)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_sel   = sel;
        reg_wdata = val;
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [31:0] val);
        @(negedge clk);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    // PHY responder: record each bit on MDC rise.
    always @(posedge mdc) begin
        if (ph_cnt < 64) begin
            cap_line[63-ph_cnt] = mdio_line;
            cap_oe[63-ph_cnt]   = mdio_oe;
            if (ph_cnt == 0) t_first = $time;
            if (ph_cnt == 1) t_second = $time;
            ph_cnt++;
            if (ph_cnt == 64) -> frame_ev;
        end
    end

    // PHY responder: drive turnaround zero and read data on MDC fall.
    always @(negedge mdc) begin
        if (ph_cnt >= 47 && ph_cnt < 64 && cap_line[29] && !cap_line[28])
            phy_drv = (ph_cnt == 47) ? 1'b0 : rsp_data[63-ph_cnt];
        else
            phy_drv = 1'b1;
    end

    // Monitor: pop the expected frame and compare with the recorded one.
    always @(frame_ev) begin
        exp_t e;
        if (sb_q.size() == 0) begin
            check(1'b0, "R9", "unexpected frame", cap_line, 64'd0);
        end else begin
            e = sb_q.pop_front();
            check(cap_line === e.line, e.rd ? "R3" : "R4", "frame bits", cap_line, e.line);
            check(cap_oe === e.oe, e.rd ? "R7" : "R4", "output enable", cap_oe, e.oe);
            check((t_second - t_first) == CLK_DIV * CLK_PERIOD, "R8", "MDC period",
                  64'(t_second - t_first), 64'(CLK_DIV * CLK_PERIOD));
        end
    end

    // Driver: queue the expected frame, program, request, poll, check result.
    // hook: 0 none, 1 read control mid-frame (R5), 2 extra request mid-frame (R9)
    task automatic do_access(input bit rd, input logic [4:0] phy, input logic [4:0] rn,
                             input logic [15:0] d, input logic [31:0] ctrl_val,
                             input int hook);
        exp_t        e;
        logic [31:0] v;
        int          n;
        e.rd   = rd;
        e.line = rd ? {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rn, 2'b10, d}
                    : {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rn, 2'b10, d};
        e.oe   = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
        sb_q.push_back(e);
        rsp_data = d;
        reg_write(3'd0, {19'd0, phy, 3'd0, rn});
        reg_write(3'd1, rd ? 32'hDEAD_0000 : {16'hBEEF, d});
        ph_cnt = 0;
        reg_write(3'd2, ctrl_val);
        reg_read(3'd3, v);
        check(v[0] == 1'b1, "R6", "busy after request", 64'(v), 64'd1);
        if (hook == 1) begin
            reg_read(3'd2, v);
            check(v == 32'h4, "R5", "control during write", 64'(v), 64'h4);
        end
        if (hook == 2) reg_write(3'd2, 32'h8);
        n = 0;
        v = 32'd1;
        while (v[0] && n < FRAME_CYC + 20) begin
            reg_read(3'd3, v);
            n++;
        end
        check(v[0] == 1'b0 && n <= FRAME_CYC + 4, "R6", "completion cycles",
              64'(n), 64'(FRAME_CYC));
        if (hook == 1) begin
            reg_read(3'd2, v);
            check(v == 32'h0, "R5", "control after frame", 64'(v), 64'h0);
        end
        if (rd) begin
            reg_read(3'd4, v);
            check(v == {16'h0, d}, "R7", "read data", 64'(v), 64'({16'h0, d}));
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "R6", "watchdog expired", 64'd1, 64'd0);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        bit          quiet;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_read(3'd3, v);
        check(v == 32'h0, "R1", "status after reset", 64'(v), 64'h0);
        reg_read(3'd4, v);
        check(v == 32'h0, "R1", "read data after reset", 64'(v), 64'h0);
        reg_read(3'd2, v);
        check(v == 32'h0, "R1", "control after reset", 64'(v), 64'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins after reset",
              64'({mdc, mdio_oe}), 64'h0);

        // R2: address register layout
        reg_write(3'd0, 32'hFFFF_FFFF);
        reg_read(3'd0, v);
        check(v == 32'h0000_1F1F, "R2", "address readback", 64'(v), 64'h1F1F);

        // R4: write frames
        do_access(1'b0, 5'h03, 5'h11, 16'hA5C3, 32'h4, 0);
        do_access(1'b0, 5'h1F, 5'h00, 16'h0001, 32'h4, 0);

        // R3 and R7: read frames with several data patterns
        do_access(1'b1, 5'h0A, 5'h02, 16'h8001, 32'h8, 0);
        do_access(1'b1, 5'h15, 5'h1F, 16'h7FFE, 32'h8, 0);
        do_access(1'b1, 5'h00, 5'h0C, 16'hFFFF, 32'h8, 0);
        do_access(1'b1, 5'h11, 5'h05, 16'h0000, 32'h8, 0);

        // R5: both request bits set gives a write and clears the read bit
        do_access(1'b0, 5'h06, 5'h09, 16'h3C5A, 32'hC, 1);

        // R9: request during a frame is ignored
        do_access(1'b0, 5'h12, 5'h14, 16'h1234, 32'h4, 2);
        repeat (20 * CLK_DIV) @(negedge clk);
        check(ph_cnt == 64, "R9", "MDC bits after ignored request", 64'(ph_cnt), 64'd64);
        check(sb_q.size() == 0, "R9", "scoreboard drained", 64'(sb_q.size()), 64'd0);
        reg_read(3'd3, v);
        check(v == 32'h0, "R9", "idle after ignored request", 64'(v), 64'h0);

        // R10: pins stay quiet while idle
        quiet = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (mdc || mdio_oe) quiet = 1'b0;
        end
        check(quiet, "R10", "idle pins low", 64'({mdc, mdio_oe}), 64'h0);

        finish_run();
    end

endmodule